// File: doc/BRIEF.md
# Block-Reset LZW Code Decompressor

This block turns a stream of LZW codewords back into the byte stream of compressed program code. It handles one compressed branch block at a time. A block-start strobe clears the phrase table, so decoding can begin at any block boundary without history from earlier blocks. Codes 0 to 255 always stand for the single bytes of the same value. Every later code names a phrase the decoder has built itself. That phrase is the phrase decoded one step earlier, extended by the first byte of the current phrase. The decoder therefore adds its entries one codeword behind the compressor.

Each table entry is stored as a prefix code plus one tail byte. To emit a phrase, the block walks the prefix chain from the tail back to the root, pushing bytes onto a stack. It then pops them out in forward order. Each codeword arrives right-aligned on a parallel input that is `MAX_W` bits wide.

The block reports the current codeword width on `cur_w`, so that an upstream bit unpacker knows how many bits to take next. This width is either a fixed value chosen per block or, in dynamic mode, a width that grows with the table. Both handshakes follow valid/ready rules:
- A codeword transfers on a clock edge where `cw_valid` and `cw_ready` are both high.
- A byte transfers on an edge where `out_valid` and `out_ready` are both high.
- `cw_ready` is high only when no bytes of the previous codeword remain to be sent.
- While `out_ready` is low, the pending byte is held.

Top module: `lzw_unpack`

## Requirements
- R1: After reset, `cw_ready` is 1, `out_valid` is 0 and `cur_w` is 9, because reset selects dynamic mode with an empty table.
- R2: A codeword below 256 produces exactly one output byte, equal to the codeword's value.
- R3: Each accepted codeword after the first in a block adds one table entry at the next free index, starting at 256. The entry is the previous phrase followed by the first byte of the current phrase. The output byte stream equals the original data, in order.
- R4: A codeword equal to the next free index decodes to the previous phrase followed by that phrase's own first byte.
- R5: In fixed mode, `cur_w` equals the width given on `fix_w` when `blk_start` was sampled, and the table holds 2^width entries. Once it is full, no entries are added, and later codewords still decode from the existing entries.
- R6: In dynamic mode, `cur_w` is the smallest width w ≥ 9 with 2^w greater than the next free index, capped at `MAX_W`. The table holds 2^`MAX_W` entries, and `cur_w` never decreases within a block.
- R7: A one-cycle `blk_start` empties the table and samples `dyn_mode` and `fix_w`. In the following cycle, `cw_ready` is 1 and `out_valid` is 0. The next codeword is treated as the first of a block.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` keeps its value. `cw_ready` and `out_valid` are never high together.
- R9: In the cycle after a codeword is accepted, `cw_ready` is 0, and every codeword yields at least one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_start | input | 1 | Start of a new block: table cleared, mode sampled |
| dyn_mode | input | 1 | 1 selects growing width, 0 selects fixed width (sampled at blk_start) |
| fix_w | input | $clog2(MAX_W+1) | Fixed codeword width, 9 to MAX_W (sampled at blk_start) |
| cw_valid | input | 1 | Codeword present |
| cw_ready | output | 1 | Decoder can take a codeword |
| cw_data | input | MAX_W | Codeword, right-aligned |
| cur_w | output | $clog2(MAX_W+1) | Width of the next codeword to be taken |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | 8 | Decoded byte |

## Verification
The assertions check the handshake rules on every cycle:
- the held byte during a stall;
- that a codeword and a pending byte are never outstanding together;
- the drop of `cw_ready` after an accept;
- the clean state after `blk_start`;
- that `cur_w` stays in range and never shrinks within a block.

Only the bench's scenarios can show the other behaviours. These are that the decoded bytes equal the original data, that the self-referencing code is expanded correctly, and that entries stop exactly at table capacity. They also include the width steps from the compressor's point of view and the independence of blocks after a reset. The bench shows these by round-tripping data through its own compressor model.

// File: rtl/lzw_pkg.sv
package lzw_pkg;
  localparam int BYTE_W = 8;
  localparam int ROOTS  = 256;
  localparam int MIN_W  = 9;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_WALK = 2'd1,
    ST_EMIT = 2'd2
  } dec_state_e;
endpackage

// File: rtl/lzw_width.sv
module lzw_width #(
  parameter int MAX_W = 10,
  localparam int NF_W = MAX_W + 1,
  localparam int WW   = $clog2(MAX_W + 1)
) (
  input  logic            dyn,
  input  logic [WW-1:0]   fixw,
  input  logic [NF_W-1:0] next_free,
  output logic [WW-1:0]   width,
  output logic [NF_W-1:0] cap
);
  import lzw_pkg::*;

  logic [WW-1:0] fw_c;

  always_comb begin
    if (int'(fixw) < MIN_W)      fw_c = WW'(MIN_W);
    else if (int'(fixw) > MAX_W) fw_c = WW'(MAX_W);
    else                         fw_c = fixw;
  end

  always_comb begin
    width = WW'(MAX_W);
    if (dyn) begin
      for (int k = MAX_W - 1; k >= MIN_W; k--) begin
        if (next_free < (NF_W'(1) << k)) width = WW'(k);
      end
    end else begin
      width = fw_c;
    end
    cap = dyn ? (NF_W'(1) << MAX_W) : (NF_W'(1) << fw_c);
  end
endmodule

// File: rtl/lzw_dict.sv
module lzw_dict #(
  parameter int MAX_W = 10,
  localparam int DEPTH = 1 << MAX_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [MAX_W-1:0] waddr,
  input  logic [MAX_W-1:0] wpref,
  input  logic [7:0]       wbyte,
  input  logic [MAX_W-1:0] raddr,
  output logic [MAX_W-1:0] rpref,
  output logic [7:0]       rbyte
);
  logic [MAX_W+7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wpref, wbyte};
  end

  assign {rpref, rbyte} = mem[raddr];
endmodule

// File: rtl/lzw_lifo.sv
module lzw_lifo #(
  parameter int MAX_W = 10,
  localparam int DEPTH = 1 << MAX_W,
  localparam int CW    = MAX_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          pop,
  output logic [7:0]    top,
  output logic [CW-1:0] count
);
  logic [7:0] mem [DEPTH];
  logic [MAX_W-1:0] top_idx;

  assign top_idx = MAX_W'(count - CW'(1));
  assign top     = mem[top_idx];

  always_ff @(posedge clk) begin
    if (push) mem[count[MAX_W-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else if (push)     count <= count + CW'(1);
    else if (pop)      count <= count - CW'(1);
  end
endmodule

// File: rtl/lzw_unpack.sv
module lzw_unpack #(
  parameter int MAX_W = 10,
  localparam int NF_W = MAX_W + 1,
  localparam int WW   = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_start,
  input  logic             dyn_mode,
  input  logic [WW-1:0]    fix_w,
  input  logic             cw_valid,
  output logic             cw_ready,
  input  logic [MAX_W-1:0] cw_data,
  output logic [WW-1:0]    cur_w,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte
);
  import lzw_pkg::*;

  dec_state_e       state;
  logic [NF_W-1:0]  next_free;
  logic [NF_W-1:0]  cap;
  logic [MAX_W-1:0] prev_code;
  logic [MAX_W-1:0] ent_pref;
  logic [MAX_W-1:0] ptr;
  logic [7:0]       prev_fb;
  logic             first;
  logic             add_pend;
  logic             dyn_r;
  logic [WW-1:0]    fixw_r;

  logic [MAX_W-1:0] d_pref;
  logic [7:0]       d_byte;
  logic             d_we;
  logic             s_push;
  logic [7:0]       s_din;
  logic             s_pop;
  logic [7:0]       s_top;
  logic [NF_W-1:0]  s_count;

  logic cw_fire, out_fire, is_root, self_ref;

  assign cw_ready  = (state == ST_WAIT);
  assign out_valid = (state == ST_EMIT);
  assign out_byte  = s_top;
  assign cw_fire   = cw_valid && cw_ready && !blk_start;
  assign out_fire  = out_valid && out_ready && !blk_start;
  assign is_root   = (ptr < MAX_W'(ROOTS));
  assign self_ref  = !first && ({1'b0, cw_data} == next_free);

  lzw_width #(.MAX_W(MAX_W)) u_width (
    .dyn(dyn_r), .fixw(fixw_r), .next_free(next_free),
    .width(cur_w), .cap(cap)
  );

  assign d_we = (state == ST_WALK) && is_root && add_pend && !blk_start;

  lzw_dict #(.MAX_W(MAX_W)) u_dict (
    .clk(clk), .we(d_we), .waddr(next_free[MAX_W-1:0]),
    .wpref(ent_pref), .wbyte(ptr[7:0]),
    .raddr(ptr), .rpref(d_pref), .rbyte(d_byte)
  );

  always_comb begin
    s_push = 1'b0;
    s_din  = 8'h00;
    if (cw_fire && self_ref) begin
      s_push = 1'b1;
      s_din  = prev_fb;
    end else if (state == ST_WALK && !blk_start) begin
      s_push = 1'b1;
      s_din  = is_root ? ptr[7:0] : d_byte;
    end
  end

  assign s_pop = out_fire;

  lzw_lifo #(.MAX_W(MAX_W)) u_lifo (
    .clk(clk), .rst_n(rst_n), .clr(blk_start),
    .push(s_push), .din(s_din), .pop(s_pop),
    .top(s_top), .count(s_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || blk_start) begin
      state     <= ST_WAIT;
      next_free <= NF_W'(ROOTS);
      first     <= 1'b1;
      add_pend  <= 1'b0;
      prev_code <= '0;
      ent_pref  <= '0;
      ptr       <= '0;
      prev_fb   <= 8'h00;
      dyn_r     <= rst_n ? dyn_mode : 1'b1;
      fixw_r    <= rst_n ? fix_w : WW'(MAX_W);
    end else begin
      case (state)
        ST_WAIT: if (cw_fire) begin
          ptr       <= self_ref ? prev_code : cw_data;
          ent_pref  <= prev_code;
          prev_code <= cw_data;
          add_pend  <= !first && (next_free < cap);
          first     <= 1'b0;
          state     <= ST_WALK;
        end
        ST_WALK: begin
          if (is_root) begin
            prev_fb <= ptr[7:0];
            if (add_pend) next_free <= next_free + NF_W'(1);
            add_pend <= 1'b0;
            state    <= ST_EMIT;
          end else begin
            ptr <= d_pref;
          end
        end
        ST_EMIT: if (out_fire && s_count == NF_W'(1)) state <= ST_WAIT;
        default: state <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/lzw_unpack_chk.sv
module lzw_unpack_chk #(
  parameter int MAX_W = 10,
  localparam int WW = $clog2(MAX_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             blk_start,
  input logic             cw_valid,
  input logic             cw_ready,
  input logic [WW-1:0]    cur_w,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_byte
);
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !blk_start) |=> (out_valid && $stable(out_byte)));

  a_r8_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(cw_ready && out_valid));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && cw_ready && !blk_start) |=> !cw_ready);

  a_r7_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> (cw_ready && !out_valid));

  a_r6_width_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cur_w) >= 9 && int'(cur_w) <= MAX_W));

  a_r6_width_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_start |=> (cur_w >= $past(cur_w)));
endmodule

bind lzw_unpack lzw_unpack_chk #(.MAX_W(MAX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_start(blk_start),
  .cw_valid(cw_valid), .cw_ready(cw_ready), .cur_w(cur_w),
  .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
);

// File: tb/lzw_unpack_tb.sv
`timescale 1ns/1ps
module lzw_unpack_tb;
  localparam int MAX_W = 10;
  localparam int WW    = $clog2(MAX_W + 1);
  localparam int TSZ   = 1 << MAX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_start = 1'b0;
  logic dyn_mode = 1'b1;
  logic [WW-1:0] fix_w = WW'(9);
  logic cw_valid = 1'b0;
  logic cw_ready;
  logic [MAX_W-1:0] cw_data = '0;
  logic [WW-1:0] cur_w;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_byte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] src[$];
  int codes[$];
  int wids[$];
  int enc_pref [TSZ];
  int enc_byte [TSZ];

  always #5 clk = ~clk;

  lzw_unpack #(.MAX_W(MAX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .dyn_mode(dyn_mode),
    .fix_w(fix_w), .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_data(cw_data),
    .cur_w(cur_w), .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int width_for(input bit dyn, input int fw, input int nf);
    int w;
    if (!dyn) return fw;
    w = 9;
    while (w < MAX_W && (1 << w) <= nf) w++;
    return w;
  endfunction

  // compressor model: codes plus the width the decoder must report for each
  task automatic encode(input bit dyn, input int fw);
    int cap, enf, cur, found, dnf;
    codes.delete();
    wids.delete();
    cap = dyn ? TSZ : (1 << fw);
    enf = 256;
    cur = src[0];
    for (int i = 1; i < src.size(); i++) begin
      found = -1;
      for (int e = 256; e < enf; e++)
        if (enc_pref[e] == cur && enc_byte[e] == int'(src[i])) found = e;
      if (found >= 0) cur = found;
      else begin
        codes.push_back(cur);
        if (enf < cap) begin
          enc_pref[enf] = cur;
          enc_byte[enf] = src[i];
          enf++;
        end
        cur = src[i];
      end
    end
    codes.push_back(cur);
    dnf = 256;
    for (int i = 0; i < codes.size(); i++) begin
      wids.push_back(width_for(dyn, fw, dnf));
      if (i > 0 && dnf < cap) dnf++;
    end
  endtask

  task automatic send_codes(input string req, input string wreq);
    for (int i = 0; i < codes.size(); i++) begin
      @(negedge clk);
      while (!cw_ready) @(negedge clk);
      check(wreq, $sformatf("cur_w before code %0d", i), int'(cur_w), wids[i]);
      cw_valid = 1'b1;
      cw_data  = MAX_W'(codes[i]);
      @(negedge clk);
      cw_valid = 1'b0;
      check("R9", "cw_ready after accept", int'(cw_ready), 0);
    end
  endtask

  task automatic recv_bytes(input string req, input int rmod);
    int idx = 0;
    bit stall = 0;
    logic [7:0] held = 8'h00;
    while (idx < src.size()) begin
      @(negedge clk);
      out_ready = (($urandom % rmod) != 0);
      #1;
      if (stall) check("R8", "held byte while stalled", int'(out_valid ? out_byte : 9'h100), int'(held));
      if (out_valid && out_ready) begin
        check(req, $sformatf("byte %0d", idx), int'(out_byte), int'(src[idx]));
        idx++;
      end
      stall = out_valid && !out_ready;
      held  = out_byte;
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_block(input bit dyn, input int fw, input string req, input string wreq, input int rmod);
    @(negedge clk);
    blk_start = 1'b1;
    dyn_mode  = dyn;
    fix_w     = WW'(fw);
    @(negedge clk);
    blk_start = 1'b0;
    check("R7", "cw_ready after block start", int'(cw_ready), 1);
    check("R7", "out_valid after block start", int'(out_valid), 0);
    encode(dyn, fw);
    fork
      send_codes(req, wreq);
      recv_bytes(req, rmod);
    join
    repeat (3) @(negedge clk);
    check(req, "no surplus bytes after block", int'(out_valid), 0);
    check(req, "idle after block", int'(cw_ready), 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", "cw_ready after reset", int'(cw_ready), 1);
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "cur_w after reset", int'(cur_w), 9);

    // R2: data with no repeated pair yields only root codes
    src = '{8'hFF, 8'h00, 8'h80, 8'h07, 8'h41};
    run_block(1'b0, 9, "R2", "R5", 3);
    check("R2", "root-only code count", codes.size(), 5);

    // R4: a run of one byte forces self-referencing codes
    src.delete();
    for (int i = 0; i < 40; i++) src.push_back(8'h61);
    run_block(1'b1, 9, "R4", "R6", 2);
    check("R4", "second code is next free index", codes[1], 256);

    // R3: small alphabet, short block
    src.delete();
    for (int i = 0; i < 400; i++) src.push_back(8'h61 + 8'($urandom % 3));
    run_block(1'b1, 9, "R3", "R6", 4);

    // R5: fixed 9-bit table filled past capacity
    src.delete();
    for (int i = 0; i < 3000; i++) src.push_back(8'($urandom % 4));
    run_block(1'b0, 9, "R5", "R5", 3);
    check("R5", "codes beyond full table", int'(codes.size() > 300), 1);

    // R6: dynamic width grows to 10 and the table reaches capacity
    src.delete();
    for (int i = 0; i < 1800; i++) src.push_back(8'($urandom));
    run_block(1'b1, 9, "R6", "R6", 2);
    n = 0;
    foreach (wids[i]) if (wids[i] == 10) n++;
    check("R6", "codes sent at width 10", int'(n > 0), 1);

    // R7: repeat an earlier style of block after reset, fixed 10 bits
    src.delete();
    for (int i = 0; i < 40; i++) src.push_back(8'h61);
    run_block(1'b0, 10, "R7", "R5", 3);
    src.delete();
    for (int i = 0; i < 600; i++) src.push_back(8'h30 + 8'((i * 7 + i / 5) % 6));
    run_block(1'b0, 10, "R7", "R5", 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule